// File: doc/BRIEF.md
# Direct-Mapped Instruction Word Cache

This block keeps recently fetched 16-bit instruction words close to an instruction fetch unit. It sits between a fetch requester and a memory read port. Every entry holds one word together with the complete byte address it came from, so a lookup is a single indexed read followed by a full-width address compare. When the stored address equals the requested one, the word comes back in the same cycle and memory is never asked. Otherwise the request is forwarded to memory unchanged. The returned word is passed through to the requester and, unless memory flagged a bus error, is also written into the entry.

The requester drives `req_valid` and `req_addr` and holds them until `resp_valid`. While a miss is outstanding, memory sees `mem_req` and `mem_addr`. It answers with a one-cycle `mem_ack` that carries `mem_data` and `mem_err`, and that answer appears on the response ports in the same cycle. A small control register selects how the cache behaves:

- enable: use the cache at all.
- freeze: keep the current contents.
- burst: a stored hint that has no effect here.
- two clear commands: wipe all entries at once.

Reset leaves the cache disabled and empty.

Top module: `iword_cache`

## Requirements
- R1: After synchronous reset, `ctl_rdata` reads 0 (cache disabled) and every entry is invalid, so no fetch hits until a fill has occurred.
- R2: While the enable bit (control bit 0) is 0, every fetch asserts `mem_req` and never hits. The memory word is returned and no entry is written, so after the cache is enabled that address still misses.
- R3: On an enabled miss, `mem_req` is 1 and `mem_addr` equals `req_addr` until `mem_ack`. In the cycle of `mem_ack`, `resp_valid` is 1, `resp_data` equals `mem_data` and `resp_hit` is 0. If `mem_err` is 0 and freeze is 0, the entry is filled at that clock edge.
- R4: A fetch of a filled address while enabled responds in the same cycle as `req_valid`. In that cycle `resp_hit` is 1, `resp_data` equals the stored word, and both `mem_req` and `resp_err` are 0.
- R5: The entry index is `req_addr[7:1]` (128 entries), and the tag is the whole 32-bit address. Two addresses with equal bits 7:1 but different upper bits replace each other. Requested addresses are even.
- R6: When `mem_ack` comes with `mem_err` = 1, the response has `resp_err` = 1 and the entry is not written, so the next fetch of that address misses.
- R7: With the freeze bit (control bit 1) set, hits are still served, but misses leave their entry unchanged.
- R8: A control write with bit 2 (clear entry) or bit 3 (clear all) set invalidates every entry. Requests in the following cycle already miss.
- R9: Control bits 0, 1 and 4 (burst) are stored and read back on `ctl_rdata`. Bits 2, 3 and 7:5 always read 0. The burst bit has no effect on hits or fills.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control write value |
| ctl_rdata | output | 8 | Control register contents |
| req_valid | input | 1 | Fetch request, held until response |
| req_addr | input | 32 | Fetch byte address (even) |
| resp_valid | output | 1 | Response word available this cycle |
| resp_data | output | 16 | Response word |
| resp_hit | output | 1 | Response served from the cache |
| resp_err | output | 1 | Response carries a memory bus error |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Memory read done (one cycle) |
| mem_data | input | 16 | Memory read word |
| mem_err | input | 1 | Memory bus error with the acknowledge |

## Verification
The hardest situation to reach is a conflict: one entry is overwritten by a second address with the same index but a different upper part, after which the first address is requested again. Uniform random addresses almost never produce this. The stimulus therefore draws addresses from a small pool that shares index bits and differs only in bits 9:8, plus the address just below all ones. Random control writes are mixed in so that freeze, disable and the clear commands land between these conflicting fills. Bus errors are injected on about one miss in eight.

// File: rtl/iword_cache_pkg.sv
package iword_cache_pkg;

    localparam int CTL_W       = 8;
    localparam int CTL_ENABLE  = 0;
    localparam int CTL_FREEZE  = 1;
    localparam int CTL_CLR_ONE = 2;
    localparam int CTL_CLR_ALL = 3;
    localparam int CTL_BURST   = 4;

    typedef struct packed {
        logic burst;
        logic freeze;
        logic enable;
    } ctl_t;

    function automatic ctl_t ctl_from_word(input logic [CTL_W-1:0] w);
        ctl_t c;
        c.burst  = w[CTL_BURST];
        c.freeze = w[CTL_FREEZE];
        c.enable = w[CTL_ENABLE];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_to_word(input ctl_t c);
        logic [CTL_W-1:0] w;
        w = '0;
        w[CTL_BURST]  = c.burst;
        w[CTL_FREEZE] = c.freeze;
        w[CTL_ENABLE] = c.enable;
        return w;
    endfunction

    function automatic logic is_clear_cmd(input logic [CTL_W-1:0] w);
        return w[CTL_CLR_ONE] | w[CTL_CLR_ALL];
    endfunction

endpackage

// File: rtl/iwc_ctrl.sv
module iwc_ctrl
    import iword_cache_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output ctl_t             ctl_q,
    output logic             inval,
    output logic [CTL_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (we) begin
            ctl_q <= ctl_from_word(wdata);
        end
    end

    // clear commands are one-shot: they only pulse the invalidate
    assign inval = we && is_clear_cmd(wdata);
    assign rdata = ctl_to_word(ctl_q);

endmodule

// File: rtl/iwc_store.sv
module iwc_store #(
    parameter int ENTRIES = 128,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              inval,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic              fill_en,
    input  logic [DATA_W-1:0] fill_data,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data
);

    localparam int IDX_W = $clog2(ENTRIES);

    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] tag_q [ENTRIES];
    logic [DATA_W-1:0] dat_q [ENTRIES];

    // word index: drop the byte bit
    assign idx = lk_addr[IDX_W:1];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic sel;
        assign sel = fill_en && (idx == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst || inval) begin
                tag_q[g] <= '1;
            end else if (sel) begin
                tag_q[g] <= lk_addr;
            end
        end

        always_ff @(posedge clk) begin
            if (sel && !inval) begin
                dat_q[g] <= fill_data;
            end
        end
    end

    assign lk_hit  = (tag_q[idx] == lk_addr);
    assign lk_data = dat_q[idx];

endmodule

// File: rtl/iword_cache.sv
module iword_cache
    import iword_cache_pkg::*;
#(
    parameter int ENTRIES = 128,
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic [DATA_W-1:0] resp_data,
    output logic              resp_hit,
    output logic              resp_err,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              mem_err
);

    ctl_t              ctl;
    logic              inval;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic              hit;
    logic              mem_done;
    logic              fill_en;

    iwc_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .ctl_q (ctl),
        .inval (inval),
        .rdata (ctl_rdata)
    );

    iwc_store #(
        .ENTRIES (ENTRIES),
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .inval     (inval),
        .lk_addr   (req_addr),
        .fill_en   (fill_en),
        .fill_data (mem_data),
        .lk_hit    (lk_hit),
        .lk_data   (lk_data)
    );

    assign hit      = req_valid && ctl.enable && lk_hit;
    assign mem_req  = req_valid && !hit;
    assign mem_addr = req_addr;
    assign mem_done = mem_req && mem_ack;

    assign fill_en  = mem_done && !mem_err && ctl.enable && !ctl.freeze;

    assign resp_valid = hit || mem_done;
    assign resp_data  = hit ? lk_data : mem_data;
    assign resp_hit   = hit;
    assign resp_err   = mem_done && mem_err;

endmodule

// File: rtl/iword_cache_chk.sv
module iword_cache_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 16,
    parameter int CTL_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_we,
    input logic [CTL_W-1:0]  ctl_wdata,
    input logic [CTL_W-1:0]  ctl_rdata,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              resp_valid,
    input logic [DATA_W-1:0] resp_data,
    input logic              resp_hit,
    input logic              resp_err,
    input logic              mem_req,
    input logic              mem_addr_ok,
    input logic              mem_ack,
    input logic [DATA_W-1:0] mem_data,
    input logic              mem_err
);

    // R1
    rst_state_chk: assert property (@(posedge clk) rst |=> (ctl_rdata == '0 || rst));

    // R9
    ctl_zero_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[3:2] == 2'b00 && ctl_rdata[7:5] == 3'b000);

    // R2
    off_miss_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !ctl_rdata[0]) |-> (!resp_hit && mem_req));

    // R4
    hit_nomem_chk: assert property (@(posedge clk) disable iff (rst)
        resp_hit |-> (resp_valid && !mem_req && !resp_err));

    // R8
    clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_we && (ctl_wdata[2] || ctl_wdata[3])) |=> !resp_hit);

    // R3
    miss_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |-> (resp_valid && mem_addr_ok && resp_data == mem_data));

    // R6
    err_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack) |-> (resp_err == mem_err));

    // R3
    refill_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst && mem_req && mem_ack && !mem_err && ctl_rdata[0] && !ctl_rdata[1]
               && !(ctl_we && (ctl_wdata[2] || ctl_wdata[3])))
         && req_valid && ctl_rdata[0] && req_addr == $past(req_addr)) |-> resp_hit);

    // R5
    align_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> !req_addr[0]);

endmodule

bind iword_cache iword_cache_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CTL_W  (iword_cache_pkg::CTL_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ctl_we      (ctl_we),
    .ctl_wdata   (ctl_wdata),
    .ctl_rdata   (ctl_rdata),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .resp_valid  (resp_valid),
    .resp_data   (resp_data),
    .resp_hit    (resp_hit),
    .resp_err    (resp_err),
    .mem_req     (mem_req),
    .mem_addr_ok (mem_addr == req_addr),
    .mem_ack     (mem_ack),
    .mem_data    (mem_data),
    .mem_err     (mem_err)
);

// File: tb/iword_cache_test.sv
module iword_cache_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        resp_valid;
    logic [15:0] resp_data;
    logic        resp_hit;
    logic        resp_err;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_data = '0;
    logic        mem_err = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [31:0] m_tag [128];
    logic [15:0] m_dat [128];
    bit m_en = 1'b0;
    bit m_fr = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    iword_cache uut (
        .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .req_valid(req_valid), .req_addr(req_addr), .resp_valid(resp_valid),
        .resp_data(resp_data), .resp_hit(resp_hit), .resp_err(resp_err),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_data(mem_data), .mem_err(mem_err)
    );

    function automatic logic [15:0] mem_word(input logic [31:0] a);
        return a[16:1] ^ a[31:16] ^ 16'hC3A5 ^ {a[8:1], a[8:1]};
    endfunction

    function automatic bit exp_hit(input logic [31:0] a);
        return m_en && (m_tag[a[7:1]] == a);
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 128; i++) m_tag[i] = '1;
    endtask

    task automatic ctl_write(input logic [7:0] w, input string req);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = w;
        @(posedge clk);
        #1;
        ctl_we = 1'b0;
        m_en = w[0];
        m_fr = w[1];
        if (w[2] || w[3]) model_clear();
        #1;
        chk(ctl_rdata == (w & 8'h13), req, "ctl readback", ctl_rdata, w & 8'h13);
    endtask

    task automatic fetch(input logic [31:0] a, input bit err, input int lat, input string req);
        bit h;
        logic [6:0] ix;
        ix = a[7:1];
        h = exp_hit(a);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        #1;
        chk(resp_hit == h, h ? "R4" : req, "hit", resp_hit, h);
        if (h) begin
            chk(resp_valid && !mem_req && resp_data == m_dat[ix] && !resp_err,
                "R4", "hit data", {resp_valid, mem_req, resp_data}, {1'b1, 1'b0, m_dat[ix]});
        end else begin
            chk(mem_req && mem_addr == a, req, "mem request", {mem_req, mem_addr}, {1'b1, a});
            if (lat > 0) begin
                chk(!resp_valid, req, "early response", resp_valid, 0);
                repeat (lat) @(negedge clk);
            end
            mem_ack  = 1'b1;
            mem_data = mem_word(a);
            mem_err  = err;
            #1;
            chk(resp_valid && resp_data == mem_word(a) && resp_err == err && !resp_hit,
                err ? "R6" : req, "miss response",
                {resp_valid, resp_err, resp_data}, {1'b1, err, mem_word(a)});
            if (!err && m_en && !m_fr) begin
                m_tag[ix] = a;
                m_dat[ix] = mem_word(a);
            end
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        mem_ack   = 1'b0;
        mem_err   = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20417));
        model_clear();
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(ctl_rdata == 8'h00, "R1", "ctl after reset", ctl_rdata, 0);

        // R2: disabled fetches do not fill
        fetch(32'h0000_0040, 1'b0, 1, "R2");
        fetch(32'h0000_0040, 1'b0, 0, "R2");
        ctl_write(8'h01, "R9");
        // R1: nothing valid after reset / disabled fetches
        fetch(32'h0000_0040, 1'b0, 2, "R1");
        // R3 fill, R4 hit
        fetch(32'h0000_0040, 1'b0, 0, "R4");
        // R5: same index, other tag evicts
        fetch(32'h0000_0140, 1'b0, 1, "R5");
        fetch(32'h0000_0040, 1'b0, 0, "R5");
        fetch(32'hFFFF_FFFE, 1'b0, 0, "R5");
        fetch(32'hFFFF_FFFE, 1'b0, 0, "R5");
        // R6: bus error leaves the entry empty
        fetch(32'h0000_0080, 1'b1, 1, "R6");
        fetch(32'h0000_0080, 1'b0, 0, "R6");
        // R7: freeze serves hits but keeps misses out
        ctl_write(8'h03, "R7");
        fetch(32'h0000_0040, 1'b0, 0, "R7");
        fetch(32'h0000_0090, 1'b0, 1, "R7");
        fetch(32'h0000_0090, 1'b0, 0, "R7");
        // R9: burst stored, clear bits read zero; R8: clear-all invalidates
        ctl_write(8'h1D, "R9");
        fetch(32'h0000_0040, 1'b0, 0, "R8");
        fetch(32'h0000_0040, 1'b0, 0, "R4");
        ctl_write(8'h05, "R8");
        fetch(32'h0000_0040, 1'b0, 0, "R8");
        ctl_write(8'hFF, "R9");
        ctl_write(8'h11, "R9");

        // random phase over a conflicting address pool
        for (int n = 0; n < 600; n++) begin
            int r;
            r = int'($urandom % 16);
            if (r == 0) begin
                logic [7:0] w;
                w = 8'($urandom);
                if (($urandom % 4) != 0) w[0] = 1'b1;
                if (($urandom % 3) != 0) w[1] = 1'b0;
                if (($urandom % 3) != 0) begin w[2] = 1'b0; w[3] = 1'b0; end
                ctl_write(w, "R9");
            end else begin
                logic [31:0] a;
                if (($urandom % 20) == 0) a = 32'hFFFF_FFFE;
                else a = (32'($urandom % 4) << 8) | (32'($urandom % 8) << 1);
                fetch(a, ($urandom % 8) == 0, int'($urandom % 3), "R3");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule